// File: doc/BRIEF.md
# Indexed Host Register Port for a Display Controller

This unit is the host-side register front end of a small display controller. The host sees a narrow I/O window. It writes a register number into the selector port, then reads or writes that register through the data port. Behind the data port sit an identity register with version negotiation, the display mode settings, a fixed capability word, an interrupt mask, a wake/busy handshake with the command engine, a 768-entry colour table (three components for each of 256 colours) and a block of scratch words placed directly after the table.

Writing any value to the wake register stores that value as a reason code, raises the busy flag and sends a one-cycle wake pulse to the command engine. Busy stays set until the command queue reports that it is empty. Interrupt events from the command engine latch into a status word that the host reads and clears through a dedicated window offset. The interrupt line is driven whenever a latched event is also enabled in the mask, provided the capability word advertises interrupt support.

Top module: `hostreg_port`

## Requirements
- R1: After synchronous reset the identity register reads 0x90000002, busy reads 0, the interrupt status reads 0, and `wake_req` and `irq` are low.
- R2: Identity values are 0x900000 shifted left by 8 and ORed with a version number from 0 to MAX_VER. Writing a legal value stores it. Writing any other value, including 0xFFFFFFFF, makes the register read the highest legal value.
- R3: The mode registers are enable (index 1, bit 0), width (index 2), height (index 3), bits per pixel (index 7) and configuration-done (index 20). Each reads back its written value truncated to its field width, and each drives its output pin.
- R4: Index 17 reads the capability word (default 0x00040000). Writes to it have no effect.
- R5: A write of any value to index 21 makes `wake_req` high for exactly the cycle after the write edge. It sets busy and stores the value, which reads back at index 21.
- R6: Busy (index 22, bit 0) stays 1 for as long as `fifo_empty` is low. It reads 0 from the first edge at which `fifo_empty` is high and no wake write is in progress.
- R7: A pulse on `irq_evt[b]` sets status bit b (bit 0 fence passed, bit 1 forward progress, bit 2 fence goal). `irq` is high while status AND mask (index 33, bits 2:0) is nonzero, and only when capability bit 18 is set.
- R8: A write to window offset 8 clears each status bit written as 1 and leaves the others. An event in the same cycle wins over the clear of its bit.
- R9: Indices 1024 to 1791 hold 8-bit colour components. Indices from 1792 hold SCRATCH_N 32-bit scratch words. Each entry reads back what was last written to it.
- R10: Any index not named in R2 to R9, including 4, 41 and the first index past the scratch block, reads 0, and writes to it change no stored state.
- R11: Window offset 0 reads back the selected index. Offsets other than 0, 1 and 8, including the firmware offset 2, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 4 | Offset within the I/O window |
| io_wr | input | 1 | Write strobe for the selected offset |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data for the selected offset (combinational) |
| fifo_empty | input | 1 | Command queue fully drained |
| irq_evt | input | 3 | Interrupt event pulses from the command engine |
| wake_req | output | 1 | One-cycle wake pulse to the command engine |
| irq | output | 1 | Interrupt line |
| disp_enable | output | 1 | Display enable setting |
| disp_width | output | 16 | Display width setting |
| disp_height | output | 16 | Display height setting |
| disp_bpp | output | 6 | Bits-per-pixel setting |
| cfg_done | output | 1 | Configuration-done flag |

## Verification
The hardest situations to reach from the ports are two same-edge collisions. One is an interrupt event arriving in the same cycle as the host's write-1-to-clear of that bit. The other is a wake write landing while the command queue already reports empty. The stimulus drives the event pulse and the offset-8 write on the same falling edge, then reads the status back. It also issues a wake write with `fifo_empty` held high and samples `wake_req` at the falling edge right after the write. Busy persistence is checked by holding `fifo_empty` low for many cycles before releasing it.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

    // window offsets
    localparam logic [3:0] OFS_INDEX = 4'd0;
    localparam logic [3:0] OFS_VALUE = 4'd1;
    localparam logic [3:0] OFS_FW    = 4'd2;
    localparam logic [3:0] OFS_IRQ   = 4'd8;

    // register indices
    localparam int IX_ID      = 0;
    localparam int IX_ENABLE  = 1;
    localparam int IX_WIDTH   = 2;
    localparam int IX_HEIGHT  = 3;
    localparam int IX_BPP     = 7;
    localparam int IX_CAPS    = 17;
    localparam int IX_CFGDONE = 20;
    localparam int IX_WAKE    = 21;
    localparam int IX_BUSY    = 22;
    localparam int IX_IRQMASK = 33;
    localparam int IX_TABLE   = 1024;

    localparam logic [23:0] ID_MAGIC    = 24'h900000;
    localparam int          CAP_IRQ_BIT = 18;

    typedef enum logic [3:0] {
        RG_NONE, RG_ID, RG_ENABLE, RG_WIDTH, RG_HEIGHT, RG_BPP, RG_CAPS,
        RG_CFGDONE, RG_WAKE, RG_BUSY, RG_IRQMASK, RG_TABLE, RG_SCRATCH
    } region_e;

    typedef struct packed {
        region_e     rg;
        logic [15:0] off;
    } decode_t;

    function automatic logic [31:0] make_id(input int ver);
        return {ID_MAGIC, 8'(ver)};
    endfunction

    function automatic logic id_legal(input logic [31:0] v, input int max_ver);
        return (v[31:8] == ID_MAGIC) && (32'(v[7:0]) <= 32'(max_ver));
    endfunction

endpackage

// File: rtl/hostreg_decode.sv
module hostreg_decode
    import hostreg_pkg::*;
#(
    parameter int TABLE_N   = 768,
    parameter int SCRATCH_N = 8
) (
    input  logic [31:0] idx,
    output decode_t     dec
);
    localparam logic [31:0] TAB_LO = 32'(IX_TABLE);
    localparam logic [31:0] SCR_LO = 32'(IX_TABLE + TABLE_N);
    localparam logic [31:0] SCR_HI = 32'(IX_TABLE + TABLE_N + SCRATCH_N);

    always_comb begin
        dec.rg  = RG_NONE;
        dec.off = '0;
        case (idx)
            32'(IX_ID):      dec.rg = RG_ID;
            32'(IX_ENABLE):  dec.rg = RG_ENABLE;
            32'(IX_WIDTH):   dec.rg = RG_WIDTH;
            32'(IX_HEIGHT):  dec.rg = RG_HEIGHT;
            32'(IX_BPP):     dec.rg = RG_BPP;
            32'(IX_CAPS):    dec.rg = RG_CAPS;
            32'(IX_CFGDONE): dec.rg = RG_CFGDONE;
            32'(IX_WAKE):    dec.rg = RG_WAKE;
            32'(IX_BUSY):    dec.rg = RG_BUSY;
            32'(IX_IRQMASK): dec.rg = RG_IRQMASK;
            default: begin
                if (idx >= TAB_LO && idx < SCR_LO) begin
                    dec.rg  = RG_TABLE;
                    dec.off = 16'(idx - TAB_LO);
                end else if (idx >= SCR_LO && idx < SCR_HI) begin
                    dec.rg  = RG_SCRATCH;
                    dec.off = 16'(idx - SCR_LO);
                end
            end
        endcase
    end
endmodule

// File: rtl/hostreg_store.sv
module hostreg_store #(
    parameter int  TABLE_N   = 768,
    parameter int  TABLE_W   = 8,
    parameter int  SCRATCH_N = 8,
    parameter int  DATA_W    = 32,
    localparam int TAB_AW    = $clog2(TABLE_N),
    localparam int SCR_AW    = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tab_we,
    input  logic              scr_we,
    input  logic [TAB_AW-1:0] tab_addr,
    input  logic [SCR_AW-1:0] scr_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [TABLE_W-1:0] tab_rd,
    output logic [DATA_W-1:0] scr_rd
);
    logic [TABLE_W-1:0] tab_mem [TABLE_N];
    logic [DATA_W-1:0]  scr_mem [SCRATCH_N];

    always_ff @(posedge clk) begin
        if (tab_we) tab_mem[tab_addr] <= wdata[TABLE_W-1:0];
        if (scr_we) scr_mem[scr_addr] <= wdata;
    end

    assign tab_rd = (32'(tab_addr) < 32'(TABLE_N))   ? tab_mem[tab_addr] : '0;
    assign scr_rd = (32'(scr_addr) < 32'(SCRATCH_N)) ? scr_mem[scr_addr] : '0;

    // R9: writes only ever land inside the storage
    p_tab_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        tab_we |-> (32'(tab_addr) < 32'(TABLE_N)));
    p_scr_in_range_r9: assert property (@(posedge clk) disable iff (rst)
        scr_we |-> (32'(scr_addr) < 32'(SCRATCH_N)));
endmodule

// File: rtl/hostreg_wake.sv
module hostreg_wake #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              fifo_empty,
    output logic              busy,
    output logic              wake_req,
    output logic [DATA_W-1:0] reason
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            wake_req <= 1'b0;
            reason   <= '0;
        end else begin
            wake_req <= wake_we;
            if (wake_we) begin
                busy   <= 1'b1;
                reason <= wdata;
            end else if (fifo_empty) begin
                busy <= 1'b0;
            end
        end
    end

    p_wake_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        wake_we |=> (wake_req && busy));
    p_wake_single_r5: assert property (@(posedge clk) disable iff (rst)
        !wake_we |=> !wake_req);
    p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !fifo_empty) |=> busy);
    p_busy_drains_r6: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty && !wake_we) |=> !busy);
endmodule

// File: rtl/hostreg_irq.sv
module hostreg_irq
    import hostreg_pkg::*;
#(
    parameter int          IRQ_N = 3,
    parameter logic [31:0] CAPS  = 32'h0004_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] evt,
    input  logic             clr_we,
    input  logic [IRQ_N-1:0] clr_bits,
    input  logic             mask_we,
    input  logic [IRQ_N-1:0] mask_wdata,
    output logic [IRQ_N-1:0] status,
    output logic [IRQ_N-1:0] mask,
    output logic             irq
);
    logic [IRQ_N-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_eff) | evt;
            if (mask_we) mask <= mask_wdata;
        end
    end

    generate
        if (CAPS[CAP_IRQ_BIT]) begin : g_irq_on
            assign irq = |(status & mask);
            // R7: the line can only rise after an event or a mask change
            p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
                $rose(irq) |-> ($past(mask_we) || $past(|evt)));
        end else begin : g_irq_off
            assign irq = 1'b0;
            p_irq_absent_r7: assert property (@(posedge clk) disable iff (rst) !irq);
        end
    endgenerate

    p_evt_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));
    p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !(|evt)) |=> ((status & $past(clr_bits)) == '0));
endmodule

// File: rtl/hostreg_port.sv
module hostreg_port
    import hostreg_pkg::*;
#(
    parameter int          DIM_W     = 16,
    parameter int          BPP_W     = 6,
    parameter int          MAX_VER   = 2,
    parameter int          COLORS    = 256,
    parameter int          SCRATCH_N = 8,
    parameter int          IRQ_N     = 3,
    parameter logic [31:0] CAPS      = 32'h0004_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       io_sel,
    input  logic             io_wr,
    input  logic [31:0]      io_wdata,
    output logic [31:0]      io_rdata,
    input  logic             fifo_empty,
    input  logic [IRQ_N-1:0] irq_evt,
    output logic             wake_req,
    output logic             irq,
    output logic             disp_enable,
    output logic [DIM_W-1:0] disp_width,
    output logic [DIM_W-1:0] disp_height,
    output logic [BPP_W-1:0] disp_bpp,
    output logic             cfg_done
);
    localparam int DATA_W  = 32;
    localparam int TABLE_N = 3 * COLORS;
    localparam int TABLE_W = 8;
    localparam int TAB_AW  = $clog2(TABLE_N);
    localparam int SCR_AW  = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;

    logic [31:0]        idx_q;
    logic [31:0]        id_q;
    decode_t            dec;
    logic               val_we;
    logic [TABLE_W-1:0] tab_rd;
    logic [DATA_W-1:0]  scr_rd;
    logic               busy;
    logic [DATA_W-1:0]  reason;
    logic [IRQ_N-1:0]   irq_status;
    logic [IRQ_N-1:0]   irq_mask;
    logic [DATA_W-1:0]  value_rd;

    assign val_we = io_wr && (io_sel == OFS_VALUE);

    hostreg_decode #(.TABLE_N(TABLE_N), .SCRATCH_N(SCRATCH_N)) u_decode (
        .idx (idx_q),
        .dec (dec)
    );

    hostreg_store #(.TABLE_N(TABLE_N), .TABLE_W(TABLE_W), .SCRATCH_N(SCRATCH_N),
                    .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .tab_we   (val_we && dec.rg == RG_TABLE),
        .scr_we   (val_we && dec.rg == RG_SCRATCH),
        .tab_addr (dec.off[TAB_AW-1:0]),
        .scr_addr (dec.off[SCR_AW-1:0]),
        .wdata    (io_wdata),
        .tab_rd   (tab_rd),
        .scr_rd   (scr_rd)
    );

    hostreg_wake #(.DATA_W(DATA_W)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .wake_we    (val_we && dec.rg == RG_WAKE),
        .wdata      (io_wdata),
        .fifo_empty (fifo_empty),
        .busy       (busy),
        .wake_req   (wake_req),
        .reason     (reason)
    );

    hostreg_irq #(.IRQ_N(IRQ_N), .CAPS(CAPS)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .evt        (irq_evt),
        .clr_we     (io_wr && io_sel == OFS_IRQ),
        .clr_bits   (io_wdata[IRQ_N-1:0]),
        .mask_we    (val_we && dec.rg == RG_IRQMASK),
        .mask_wdata (io_wdata[IRQ_N-1:0]),
        .status     (irq_status),
        .mask       (irq_mask),
        .irq        (irq)
    );

    // selector, identity and mode registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q       <= '0;
            id_q        <= make_id(MAX_VER);
            disp_enable <= 1'b0;
            disp_width  <= '0;
            disp_height <= '0;
            disp_bpp    <= '0;
            cfg_done    <= 1'b0;
        end else begin
            if (io_wr && io_sel == OFS_INDEX) idx_q <= io_wdata;
            if (val_we) begin
                case (dec.rg)
                    RG_ID:      id_q <= id_legal(io_wdata, MAX_VER) ? io_wdata
                                                                    : make_id(MAX_VER);
                    RG_ENABLE:  disp_enable <= io_wdata[0];
                    RG_WIDTH:   disp_width  <= io_wdata[DIM_W-1:0];
                    RG_HEIGHT:  disp_height <= io_wdata[DIM_W-1:0];
                    RG_BPP:     disp_bpp    <= io_wdata[BPP_W-1:0];
                    RG_CFGDONE: cfg_done    <= io_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (dec.rg)
            RG_ID:      value_rd = id_q;
            RG_ENABLE:  value_rd = DATA_W'(disp_enable);
            RG_WIDTH:   value_rd = DATA_W'(disp_width);
            RG_HEIGHT:  value_rd = DATA_W'(disp_height);
            RG_BPP:     value_rd = DATA_W'(disp_bpp);
            RG_CAPS:    value_rd = CAPS;
            RG_CFGDONE: value_rd = DATA_W'(cfg_done);
            RG_WAKE:    value_rd = reason;
            RG_BUSY:    value_rd = DATA_W'(busy);
            RG_IRQMASK: value_rd = DATA_W'(irq_mask);
            RG_TABLE:   value_rd = DATA_W'(tab_rd);
            RG_SCRATCH: value_rd = scr_rd;
            default:    value_rd = '0;
        endcase
    end

    always_comb begin
        case (io_sel)
            OFS_INDEX: io_rdata = idx_q;
            OFS_VALUE: io_rdata = value_rd;
            OFS_IRQ:   io_rdata = DATA_W'(irq_status);
            default:   io_rdata = '0;
        endcase
    end

    // R2: the identity register never holds an unsupported value
    p_id_legal_r2: assert property (@(posedge clk) disable iff (rst)
        id_legal(id_q, MAX_VER));
    // R10: unmapped indices never return data
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (io_sel == OFS_VALUE && dec.rg == RG_NONE) |-> (io_rdata == '0));
    // R4: capability word is constant at the port
    p_caps_fixed_r4: assert property (@(posedge clk) disable iff (rst)
        (io_sel == OFS_VALUE && dec.rg == RG_CAPS) |-> (io_rdata == CAPS));
endmodule

// File: tb/hostreg_port_tb.sv
`timescale 1ns/100ps
module hostreg_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  io_sel = 4'd0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        fifo_empty = 1'b1;
    logic [2:0]  irq_evt = '0;
    logic        wake_req, irq, disp_enable, cfg_done;
    logic [15:0] disp_width, disp_height;
    logic [5:0]  disp_bpp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hostreg_port u_dut (
        .clk(clk), .rst(rst), .io_sel(io_sel), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .fifo_empty(fifo_empty), .irq_evt(irq_evt),
        .wake_req(wake_req), .irq(irq), .disp_enable(disp_enable),
        .disp_width(disp_width), .disp_height(disp_height), .disp_bpp(disp_bpp),
        .cfg_done(cfg_done)
    );

    // scoreboard: kind 0 rdata, 1 wake_req, 2 irq, 3 disp_width, 4 disp_enable
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    event  chk_ev;

    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = io_rdata;
                    1:       act = {31'b0, wake_req};
                    2:       act = {31'b0, irq};
                    3:       act = {16'b0, disp_width};
                    default: act = {31'b0, disp_enable};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        #0.3;
        sb.push_back(it);
        -> chk_ev;
        #0.3;
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        io_sel = sel; io_wr = 1'b1; io_wdata = d;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic wreg(input int idx, input logic [31:0] d);
        wr(4'd0, 32'(idx));
        wr(4'd1, d);
    endtask

    task automatic expect_rd(input logic [3:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        io_sel = sel;
        push(0, exp, tag);
    endtask

    task automatic rreg(input int idx, input logic [31:0] exp, input string tag);
        wr(4'd0, 32'(idx));
        expect_rd(4'd1, exp, tag);
    endtask

    task automatic pulse_evt(input logic [2:0] b);
        @(negedge clk);
        irq_evt = b;
        @(negedge clk);
        irq_evt = '0;
    endtask

    initial begin
        #(4 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        push(1, 0, "R1 wake_req low");
        push(2, 0, "R1 irq low");
        rreg(0, 32'h9000_0002, "R1 id reset");
        rreg(22, 0, "R1 busy reset");
        expect_rd(4'd8, 0, "R1 status reset");

        // R2 identity negotiation
        wreg(0, 32'h9000_0000);
        rreg(0, 32'h9000_0000, "R2 legal id v0");
        wreg(0, 32'h9000_0001);
        rreg(0, 32'h9000_0001, "R2 legal id v1");
        wreg(0, 32'hFFFF_FFFF);
        rreg(0, 32'h9000_0002, "R2 invalid id");
        wreg(0, 32'h9000_0003);
        rreg(0, 32'h9000_0002, "R2 version above max");

        // R3 mode registers
        wreg(2, 32'h1234_5678);
        rreg(2, 32'h0000_5678, "R3 width truncated");
        push(3, 32'h0000_5678, "R3 width pin");
        wreg(1, 32'hFFFF_FFFF);
        rreg(1, 32'h1, "R3 enable bit");
        push(4, 32'h1, "R3 enable pin");
        wreg(3, 32'h0000_0300);
        rreg(3, 32'h0000_0300, "R3 height");
        wreg(7, 32'd32);
        rreg(7, 32'd32, "R3 bpp");
        wreg(20, 32'h1);
        rreg(20, 32'h1, "R3 config done");

        // R4 capability word
        wreg(17, 32'h0);
        rreg(17, 32'h0004_0000, "R4 caps read-only");

        // R5 wake while queue already empty
        fifo_empty = 1'b1;
        wreg(21, 32'h55);
        push(1, 1, "R5 wake pulse empty queue");
        @(negedge clk);
        push(1, 0, "R5 wake pulse single cycle");
        rreg(21, 32'h55, "R5 reason stored");
        rreg(22, 0, "R6 busy drops when empty");

        // R5/R6 wake with pending commands
        @(negedge clk);
        fifo_empty = 1'b0;
        wreg(21, 32'hAB);
        push(1, 1, "R5 wake pulse");
        @(negedge clk);
        push(1, 0, "R5 wake drops");
        repeat (10) @(negedge clk);
        rreg(22, 1, "R6 busy held while queue busy");
        rreg(21, 32'hAB, "R5 reason updated");
        wr(4'd0, 32'd22);
        fifo_empty = 1'b1;
        expect_rd(4'd1, 0, "R6 busy cleared after drain");

        // R7/R8 interrupts
        pulse_evt(3'b001);
        push(2, 0, "R7 irq masked off");
        expect_rd(4'd8, 32'h1, "R7 fence status set");
        wreg(33, 32'h2);
        push(2, 0, "R7 irq mask other bit");
        rreg(33, 32'h2, "R7 mask readback");
        pulse_evt(3'b010);
        push(2, 1, "R7 irq raised");
        expect_rd(4'd8, 32'h3, "R7 status two bits");
        @(negedge clk);
        io_sel = 4'd8; io_wr = 1'b1; io_wdata = 32'h2; irq_evt = 3'b010;
        @(negedge clk);
        io_wr = 1'b0; irq_evt = '0;
        expect_rd(4'd8, 32'h3, "R8 event beats clear");
        wr(4'd8, 32'h1);
        expect_rd(4'd8, 32'h2, "R8 clear one bit");
        push(2, 1, "R8 irq stays");
        wr(4'd8, 32'h2);
        push(2, 0, "R8 irq cleared");
        expect_rd(4'd8, 32'h0, "R8 status empty");

        // R9 colour table and scratch
        wreg(1024, 32'h1FF);
        wreg(1791, 32'h5A);
        rreg(1024, 32'hFF, "R9 table first entry");
        rreg(1791, 32'h5A, "R9 table last entry");
        wreg(1792, 32'hDEAD_BEEF);
        wreg(1799, 32'h1234_5678);
        rreg(1792, 32'hDEAD_BEEF, "R9 scratch first");
        rreg(1799, 32'h1234_5678, "R9 scratch last");

        // R10 unmapped indices
        wreg(1800, 32'hFFFF_FFFF);
        rreg(1800, 0, "R10 past scratch reads zero");
        rreg(1792, 32'hDEAD_BEEF, "R10 no alias into scratch");
        wreg(41, 32'h5);
        rreg(41, 0, "R10 index 41");
        rreg(4, 0, "R10 index 4");
        wreg(1023, 32'h77);
        rreg(1023, 0, "R10 below table");
        rreg(1791, 32'h5A, "R10 table untouched");

        // R11 window offsets
        wr(4'd0, 32'd1025);
        expect_rd(4'd0, 32'd1025, "R11 index readback");
        expect_rd(4'd2, 0, "R11 firmware offset");
        expect_rd(4'd5, 0, "R11 unused offset");

        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule